// File: doc/BRIEF.md
# Bank-Switchable Dual-Port Memory

This block is a shared word memory with a left and a right access port. The storage is cut into four equal banks. A four-bit ownership input outside the block hands each bank to exactly one port. A port can read and write only the banks it owns. Both ports may work in the same cycle, as long as each uses a bank of its own. An access to a bank the port does not own is blocked and reported with a one-cycle fault pulse on that port.

Each port has a two-part enable, a read/write strobe, an output enable, two byte enables and a bank and word address. It also has a side-channel select input, which in this model only suppresses memory access. All inputs are sampled on the rising clock edge. Read data and its valid flag appear one cycle after the request. The ownership input is registered, so a change governs accesses from the following edge on.

Top module: `bank_switch_dpram`

## Requirements
- R1: A port is active only when its low-true enable `*_en_n` is 0 and its high-true enable `*_en` is 1. Any other combination writes nothing, gives `*_rv` = 0 and `*_rd` = 0 on the next cycle, and raises no fault.
- R2: A write stores data at index {bank, word}. A read of an owned bank returns the stored word on `*_rd` with `*_rv` = 1 in the cycle after the request.
- R3: `*_hi_n` = 0 enables bits 15:8 and `*_lo_n` = 0 enables bits 7:0, for writes and for reads. A disabled byte is not written and reads back as 0. With both set to 1, nothing is written and `*_rv` stays 0.
- R4: A read with `*_oe_n` = 1 gives `*_rv` = 0 and `*_rd` = 0. Whenever `*_rv` is 0, `*_rd` is 0.
- R5: In `own_left`, bit b = 1 gives bank b to the left port and bit b = 0 gives it to the right port. The value is registered. An access in the same cycle as a change is judged against the previous ownership, and the new ownership applies from the following cycle.
- R6: An active access to a bank the port does not own writes nothing and returns no data. It raises `*_fault` for exactly one cycle, in the cycle after the request.
- R7: While `*_mbx_n` = 0, the port performs no memory access and raises no fault, whatever bank it addresses.
- R8: The two ports can access different banks in the same cycle, and the two accesses do not affect each other.
- R9: During reset, `*_rv`, `*_fault` and `*_rd` are 0, and every bank belongs to the right port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| own_left | input | 4 | Per-bank owner: 1 = left, 0 = right |
| l_en_n | input | 1 | Left enable, active low |
| l_en | input | 1 | Left enable, active high |
| l_wr_n | input | 1 | Left 0 = write, 1 = read |
| l_oe_n | input | 1 | Left read output enable, active low |
| l_hi_n | input | 1 | Left upper byte enable, active low |
| l_lo_n | input | 1 | Left lower byte enable, active low |
| l_mbx_n | input | 1 | Left side-channel select, active low |
| l_bk | input | 2 | Left bank address |
| l_adr | input | AW | Left word address |
| l_wd | input | 16 | Left write data |
| l_rd | output | 16 | Left read data |
| l_rv | output | 1 | Left read data valid |
| l_fault | output | 1 | Left non-owned access pulse |
| r_en_n | input | 1 | Right enable, active low |
| r_en | input | 1 | Right enable, active high |
| r_wr_n | input | 1 | Right 0 = write, 1 = read |
| r_oe_n | input | 1 | Right read output enable, active low |
| r_hi_n | input | 1 | Right upper byte enable, active low |
| r_lo_n | input | 1 | Right lower byte enable, active low |
| r_mbx_n | input | 1 | Right side-channel select, active low |
| r_bk | input | 2 | Right bank address |
| r_adr | input | AW | Right word address |
| r_wd | input | 16 | Right write data |
| r_rd | output | 16 | Right read data |
| r_rv | output | 1 | Right read data valid |
| r_fault | output | 1 | Right non-owned access pulse |

## Verification
The case that needs care is an ownership change arriving in the same cycle as an access to the bank being moved. The bench drives a new `own_left` value on the same falling edge as a right-port read of a bank that is moving to the right port. It expects a fault, because the access is judged against the old owner. On the next cycle, the same read must return the word the left port wrote earlier. The same test also drives both ports together into their own banks, so the collision-free dual access is judged in one cycle.

// File: rtl/bank_switch_dpram.sv
module bank_switch_dpram #(
  parameter int DW = 16,
  parameter int AW = 8,
  parameter int NB = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NB-1:0]          own_left,
  input  logic                   l_en_n,
  input  logic                   l_en,
  input  logic                   l_wr_n,
  input  logic                   l_oe_n,
  input  logic                   l_hi_n,
  input  logic                   l_lo_n,
  input  logic                   l_mbx_n,
  input  logic [$clog2(NB)-1:0]  l_bk,
  input  logic [AW-1:0]          l_adr,
  input  logic [DW-1:0]          l_wd,
  output logic [DW-1:0]          l_rd,
  output logic                   l_rv,
  output logic                   l_fault,
  input  logic                   r_en_n,
  input  logic                   r_en,
  input  logic                   r_wr_n,
  input  logic                   r_oe_n,
  input  logic                   r_hi_n,
  input  logic                   r_lo_n,
  input  logic                   r_mbx_n,
  input  logic [$clog2(NB)-1:0]  r_bk,
  input  logic [AW-1:0]          r_adr,
  input  logic [DW-1:0]          r_wd,
  output logic [DW-1:0]          r_rd,
  output logic                   r_rv,
  output logic                   r_fault
);
  localparam int BKW = $clog2(NB);
  localparam int IW  = BKW + AW;
  localparam int TOT = NB << AW;
  localparam int HB  = DW / 2;

  logic [DW-1:0] mem [TOT];
  logic [NB-1:0] own_q;

  logic [1:0]          en_n, en, wr_n, oe_n, hi_n, lo_n, mbx_n;
  logic [1:0][BKW-1:0] bk;
  logic [1:0][AW-1:0]  adr;
  logic [1:0][DW-1:0]  wd, rd_q;
  logic [1:0][IW-1:0]  ix;
  logic [1:0]          act, mine, go, rv_q, flt_q;

  assign en_n  = {r_en_n, l_en_n};
  assign en    = {r_en, l_en};
  assign wr_n  = {r_wr_n, l_wr_n};
  assign oe_n  = {r_oe_n, l_oe_n};
  assign hi_n  = {r_hi_n, l_hi_n};
  assign lo_n  = {r_lo_n, l_lo_n};
  assign mbx_n = {r_mbx_n, l_mbx_n};
  assign bk    = {r_bk, l_bk};
  assign adr   = {r_adr, l_adr};
  assign wd    = {r_wd, l_wd};

  for (genvar p = 0; p < 2; p++) begin : g_port
    assign act[p]  = !en_n[p] && en[p] && mbx_n[p];
    assign mine[p] = (p == 0) ? own_q[bk[p]] : !own_q[bk[p]];
    assign go[p]   = act[p] && mine[p];
    assign ix[p]   = {bk[p], adr[p]};
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) own_q <= '0;
    else        own_q <= own_left;

  always_ff @(posedge clk)
    for (int p = 0; p < 2; p++)
      if (go[p] && !wr_n[p]) begin
        if (!hi_n[p]) mem[ix[p]][DW-1:HB] <= wd[p][DW-1:HB];
        if (!lo_n[p]) mem[ix[p]][HB-1:0]  <= wd[p][HB-1:0];
      end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_q  <= '0;
      rv_q  <= '0;
      flt_q <= '0;
    end else begin
      for (int p = 0; p < 2; p++) begin
        flt_q[p] <= act[p] && !mine[p];
        if (go[p] && wr_n[p] && !oe_n[p] && !(hi_n[p] && lo_n[p])) begin
          rv_q[p] <= 1'b1;
          rd_q[p] <= {hi_n[p] ? {(DW-HB){1'b0}} : mem[ix[p]][DW-1:HB],
                      lo_n[p] ? {HB{1'b0}}      : mem[ix[p]][HB-1:0]};
        end else begin
          rv_q[p] <= 1'b0;
          rd_q[p] <= '0;
        end
      end
    end

  assign l_rd    = rd_q[0];
  assign r_rd    = rd_q[1];
  assign l_rv    = rv_q[0];
  assign r_rv    = rv_q[1];
  assign l_fault = flt_q[0];
  assign r_fault = flt_q[1];
endmodule

// File: rtl/bank_switch_dpram_chk.sv
module bank_switch_dpram_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          l_en_n,
  input logic          l_en,
  input logic          l_oe_n,
  input logic          l_hi_n,
  input logic          l_lo_n,
  input logic          l_mbx_n,
  input logic [DW-1:0] l_rd,
  input logic          l_rv,
  input logic          l_fault,
  input logic          r_en_n,
  input logic          r_en,
  input logic          r_oe_n,
  input logic          r_hi_n,
  input logic          r_lo_n,
  input logic          r_mbx_n,
  input logic [DW-1:0] r_rd,
  input logic          r_rv,
  input logic          r_fault
);
  a_r1_left_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (l_en_n || !l_en) |=> (!l_rv && !l_fault && l_rd == '0));
  a_r1_right_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (r_en_n || !r_en) |=> (!r_rv && !r_fault && r_rd == '0));
  a_r3_no_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    (l_hi_n && l_lo_n) |=> !l_rv);
  a_r4_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
    r_oe_n |=> !r_rv);
  a_r4_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_rv |-> l_rd == '0) and (!r_rv |-> r_rd == '0));
  a_r6_fault_no_data: assert property (@(posedge clk) disable iff (!rst_n)
    !(l_fault && l_rv) && !(r_fault && r_rv));
  a_r7_side_select: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_mbx_n && !r_mbx_n) |=> (!l_rv && !l_fault && !r_rv && !r_fault));
endmodule

bind bank_switch_dpram bank_switch_dpram_chk #(.DW(DW)) u_chk (.*);

// File: tb/sim_bank_switch_dpram.sv
`timescale 1ns/1ps
module sim_bank_switch_dpram;
  localparam int AW = 8;
  logic clk = 0, rst_n = 0;
  logic [3:0] own_left;
  logic l_en_n, l_en, l_wr_n, l_oe_n, l_hi_n, l_lo_n, l_mbx_n;
  logic r_en_n, r_en, r_wr_n, r_oe_n, r_hi_n, r_lo_n, r_mbx_n;
  logic [1:0] l_bk, r_bk;
  logic [AW-1:0] l_adr, r_adr;
  logic [15:0] l_wd, r_wd, l_rd, r_rd;
  logic l_rv, r_rv, l_fault, r_fault;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bank_switch_dpram #(.AW(AW)) u0 (.*);

  function automatic logic [15:0] pat(int b, int a);
    return 16'((b * 945 + a * 215) ^ 16'hA5C3);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic lport(logic e_n, e, w_n, o_n, h_n, b_n, m_n,
                       logic [1:0] b, logic [AW-1:0] a, logic [15:0] d);
    l_en_n = e_n; l_en = e; l_wr_n = w_n; l_oe_n = o_n;
    l_hi_n = h_n; l_lo_n = b_n; l_mbx_n = m_n; l_bk = b; l_adr = a; l_wd = d;
  endtask

  task automatic rport(logic e_n, e, w_n, o_n, h_n, b_n, m_n,
                       logic [1:0] b, logic [AW-1:0] a, logic [15:0] d);
    r_en_n = e_n; r_en = e; r_wr_n = w_n; r_oe_n = o_n;
    r_hi_n = h_n; r_lo_n = b_n; r_mbx_n = m_n; r_bk = b; r_adr = a; r_wd = d;
  endtask

  task automatic lidle; lport(1, 0, 1, 1, 1, 1, 1, 0, 0, 0); endtask
  task automatic ridle; rport(1, 0, 1, 1, 1, 1, 1, 0, 0, 0); endtask
  task automatic lrd(logic [1:0] b, logic [AW-1:0] a); lport(0, 1, 1, 0, 0, 0, 1, b, a, 0); endtask
  task automatic rrd(logic [1:0] b, logic [AW-1:0] a); rport(0, 1, 1, 0, 0, 0, 1, b, a, 0); endtask
  task automatic lwr(logic [1:0] b, logic [AW-1:0] a, logic [15:0] d); lport(0, 1, 0, 1, 0, 0, 1, b, a, d); endtask
  task automatic rwr(logic [1:0] b, logic [AW-1:0] a, logic [15:0] d); rport(0, 1, 0, 1, 0, 0, 1, b, a, d); endtask

  initial begin
    own_left = 4'h0; lidle(); ridle();
    repeat (3) step();
    chk("R9 reset outputs", {l_rv, r_rv, l_fault, r_fault, l_rd, r_rd}, 0);
    rst_n = 1;
    rwr(0, 1, 16'h7777); step();
    chk("R9 right owns bank0 after reset", r_fault, 0);
    ridle();
    own_left = 4'hF; step();
    for (int b = 0; b < 4; b++)
      for (int a = 0; a < (1 << AW); a++) begin
        lwr(2'(b), AW'(a), pat(b, a)); step();
      end
    for (int b = 0; b < 4; b++)
      for (int a = 0; a < (1 << AW); a++) begin
        lrd(2'(b), AW'(a)); rrd(2'(b), AW'(a)); step();
        chk("R2 read data", {l_rv, l_rd}, {1'b1, pat(b, a)});
        chk("R6 non-owned read", {r_fault, r_rv, r_rd}, {2'b10, 16'h0});
      end
    lidle(); ridle(); step();
    chk("R6 fault lasts one cycle", r_fault, 0);

    own_left = 4'b0101; rrd(1, 5); step();
    chk("R5 change same cycle uses old owner", {r_fault, r_rv}, 2'b10);
    rrd(1, 5); lrd(0, 7); step();
    chk("R5 new owner reads", {r_fault, r_rv, r_rd}, {2'b01, pat(1, 5)});
    chk("R8 left in parallel", {l_rv, l_rd}, {1'b1, pat(0, 7)});
    rwr(3, 9, 16'h1234); lwr(2, 9, 16'hBEEF); step();
    rrd(3, 9); lrd(2, 9); step();
    chk("R8 right parallel write", {r_rv, r_rd}, {1'b1, 16'h1234});
    chk("R8 left parallel write", {l_rv, l_rd}, {1'b1, 16'hBEEF});

    ridle(); lidle();
    rwr(0, 3, 16'hDEAD); step();
    chk("R6 non-owned write fault", r_fault, 1);
    ridle(); step();
    chk("R6 pulse ends", r_fault, 0);
    lrd(0, 3); step();
    chk("R6 write blocked", {l_rv, l_rd}, {1'b1, pat(0, 3)});

    lport(0, 1, 0, 1, 0, 1, 1, 0, 4, 16'hABCD); step();
    lrd(0, 4); step();
    chk("R3 upper byte write", l_rd, {8'hAB, pat(0, 4)[7:0]});
    lport(0, 1, 0, 1, 1, 0, 1, 0, 4, 16'h1122); step();
    lport(0, 1, 1, 0, 1, 0, 1, 0, 4, 0); step();
    chk("R3 lower byte read", {l_rv, l_rd}, {1'b1, 16'h0022});
    lport(0, 1, 1, 0, 0, 1, 1, 0, 4, 0); step();
    chk("R3 upper byte read", {l_rv, l_rd}, {1'b1, 16'hAB00});
    lport(0, 1, 0, 1, 1, 1, 1, 0, 4, 16'hFFFF); step();
    lport(0, 1, 1, 0, 1, 1, 1, 0, 4, 0); step();
    chk("R3 no bytes read", {l_rv, l_rd}, 0);
    lrd(0, 4); step();
    chk("R3 no bytes write", l_rd, 16'hAB22);

    lport(0, 1, 1, 1, 0, 0, 1, 0, 4, 0); step();
    chk("R4 output disabled", {l_rv, l_rd}, 0);

    lport(0, 0, 0, 1, 0, 0, 1, 0, 5, 0); step();
    chk("R1 second enable low", {l_rv, l_fault}, 0);
    lport(1, 1, 0, 1, 0, 0, 1, 0, 5, 0); step();
    lport(1, 1, 1, 0, 0, 0, 1, 0, 5, 0); step();
    chk("R1 idle read", {l_rv, l_rd}, 0);
    lrd(0, 5); step();
    chk("R1 writes ignored", l_rd, pat(0, 5));

    lport(0, 1, 0, 1, 0, 0, 0, 1, 2, 16'h0BAD); step();
    chk("R7 no fault on side select", l_fault, 0);
    lport(0, 1, 0, 1, 0, 0, 0, 0, 6, 16'h0BAD);
    rport(0, 1, 1, 0, 0, 0, 0, 1, 5, 0); step();
    chk("R7 right no read", {r_rv, r_rd}, 0);
    lrd(0, 6); ridle(); step();
    chk("R7 write suppressed", l_rd, pat(0, 6));

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule